// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit

This block is the arithmetic core of a 16-bit signal-processing datapath. Each clock it can take two 16-bit operands, form their product, and do one of four things with it. It can add the product to one of two 40-bit accumulators, subtract the product from it, load the product into it, or clear it. All of this finishes in the same cycle. Operand fetch, address generation, instruction decode and accumulator shifting belong to neighbouring blocks.

Each operand has its own signedness select. The unit widens each operand to 17 bits by sign or zero extension before multiplying. One 17x17 signed multiplier therefore covers signed, unsigned and mixed-sign products. In fractional mode the product is doubled before it is sign-extended, which places it in 9.31 format. In this format (-1.0)x(-1.0) gives an exact +1.0.

Accumulation may wrap or saturate. Each accumulator carries a sticky overflow flag that only a clear operation resets.

Top module: `mac_unit`

## Requirements
- R1: While `rst_n` is low, and right after it is released, both accumulators read zero and both overflow flags are low.
- R2: With `op_en` high, `op_sel`=2'b01 adds the product to the selected accumulator. The sum appears at the outputs after the next rising clock edge. With both signedness selects high and `frac_mode` low, the product is the signed integer product.
- R3: When an operand's select (`a_signed`, `b_signed`) is low, that operand is zero-extended; when it is high, the operand is sign-extended. This covers unsigned x unsigned and mixed-sign products.
- R4: With `frac_mode` high, the product is doubled. Signed 0x8000 x 0x8000 therefore gives exactly 0x00_8000_0000 without overflow.
- R5: `op_sel`=2'b10 subtracts the product from the selected accumulator.
- R6: `op_sel`=2'b00 loads the product into the selected accumulator and discards its previous value. The overflow flag is left unchanged.
- R7: With `sat_en` high, an add or subtract whose true result leaves the signed 40-bit range sets the accumulator to 0x7F_FFFF_FFFF or 0x80_0000_0000, depending on the direction of the overflow.
- R8: With `sat_en` low, such a result wraps modulo 2^40.
- R9: Any overflow, whether saturated or wrapped, sets the selected accumulator's flag. The flag stays set until `op_sel`=2'b11 clears both that accumulator and its flag.
- R10: `acc_sel`=0 selects accumulator A and 1 selects B. The unselected accumulator and its flag keep their values. With `op_en` low, both accumulators and both flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_en | input | 1 | Apply the operation this cycle |
| op_sel | input | 2 | 00 load, 01 add, 10 subtract, 11 clear |
| acc_sel | input | 1 | 0 = accumulator A, 1 = accumulator B |
| frac_mode | input | 1 | 1 = fractional (product doubled) |
| a_signed | input | 1 | Operand A is signed |
| b_signed | input | 1 | Operand B is signed |
| sat_en | input | 1 | Saturate instead of wrap |
| opa | input | 16 | Operand A |
| opb | input | 16 | Operand B |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ovf_a | output | 1 | Sticky overflow flag of A |
| ovf_b | output | 1 | Sticky overflow flag of B |

## Verification
Both accumulators and their flags are visible at the ports. A wrong internal value therefore shows on the first clock edge after the operation that produced it. A wrong product, extension or shift shows in the same way, one edge after a load. A bad overflow decision or a lost flag stays wrong from then on, because later sums build on it. Comparing every output against a behavioural model after every edge catches an error on the cycle it is made. This includes errors in the idle and unselected accumulator.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [1:0] {
        OP_MPY = 2'b00,
        OP_MAC = 2'b01,
        OP_MSC = 2'b10,
        OP_CLR = 2'b11
    } mac_op_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int OPW  = 16,
    parameter int ACCW = 40
) (
    input  logic [OPW-1:0]         opa,
    input  logic [OPW-1:0]         opb,
    input  logic                   a_signed,
    input  logic                   b_signed,
    input  logic                   frac_mode,
    output logic signed [ACCW-1:0] prod
);
    localparam int EXTW  = OPW + 1;
    localparam int PRODW = 2 * EXTW;
    localparam logic [ACCW-1:0] FRAC_ONE = ACCW'(1) << (2 * OPW - 1);
    localparam logic [OPW-1:0]  MINUS_ONE = {1'b1, {(OPW-1){1'b0}}};

    logic signed [EXTW-1:0]  a_x, b_x;
    logic signed [PRODW-1:0] raw;
    logic signed [PRODW:0]   scaled;

    always_comb begin
        a_x    = {a_signed & opa[OPW-1], opa};
        b_x    = {b_signed & opb[OPW-1], opb};
        raw    = a_x * b_x;
        scaled = frac_mode ? {raw, 1'b0} : {raw[PRODW-1], raw};
        prod   = {{(ACCW-PRODW-1){scaled[PRODW]}}, scaled};
    end

    // (-1.0)x(-1.0) must come out as exactly +1.0
    always_comb begin
        if (frac_mode && a_signed && b_signed && opa == MINUS_ONE && opb == MINUS_ONE)
            assert_minus_one_sq_R4: assert (prod == FRAC_ONE);
    end
endmodule

// File: rtl/mac_lane.sv
module mac_lane
    import mac_pkg::*;
#(
    parameter int ACCW = 40
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  mac_op_e                op,
    input  logic                   sat_en,
    input  logic signed [ACCW-1:0] prod,
    output logic [ACCW-1:0]        acc,
    output logic                   ovf
);
    localparam logic [ACCW-1:0] POS_MAX = {1'b0, {(ACCW-1){1'b1}}};
    localparam logic [ACCW-1:0] NEG_MAX = {1'b1, {(ACCW-1){1'b0}}};

    logic [ACCW:0]   sum;
    logic            out_of_range;
    logic [ACCW-1:0] nxt_acc;
    logic            nxt_ovf;

    always_comb begin
        if (op == OP_MSC)
            sum = {acc[ACCW-1], acc} - {prod[ACCW-1], prod};
        else
            sum = {acc[ACCW-1], acc} + {prod[ACCW-1], prod};
        out_of_range = sum[ACCW] ^ sum[ACCW-1];
        nxt_acc = acc;
        nxt_ovf = ovf;
        unique case (op)
            OP_MPY: nxt_acc = prod;
            OP_MAC, OP_MSC: begin
                if (out_of_range) begin
                    nxt_ovf = 1'b1;
                    nxt_acc = !sat_en ? sum[ACCW-1:0] : (sum[ACCW] ? NEG_MAX : POS_MAX);
                end else begin
                    nxt_acc = sum[ACCW-1:0];
                end
            end
            OP_CLR: begin
                nxt_acc = '0;
                nxt_ovf = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            ovf <= 1'b0;
        end else if (en) begin
            acc <= nxt_acc;
            ovf <= nxt_ovf;
        end
    end

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_CLR) |=> (acc == '0 && !ovf));
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(en && op == OP_CLR)) |=> ovf);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(acc) && $stable(ovf)));
    assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_MPY) |=> (acc == $past(prod) && ovf == $past(ovf)));
    assert_pos_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sat_en && op == OP_MAC && !acc[ACCW-1] && !prod[ACCW-1]) |=> !acc[ACCW-1]);
endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int OPW  = 16,
    parameter int ACCW = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_en,
    input  logic [1:0]      op_sel,
    input  logic            acc_sel,
    input  logic            frac_mode,
    input  logic            a_signed,
    input  logic            b_signed,
    input  logic            sat_en,
    input  logic [OPW-1:0]  opa,
    input  logic [OPW-1:0]  opb,
    output logic [ACCW-1:0] acc_a,
    output logic [ACCW-1:0] acc_b,
    output logic            ovf_a,
    output logic            ovf_b
);
    localparam int NACC = 2;

    logic signed [ACCW-1:0] prod;
    logic [ACCW-1:0]        lane_acc [NACC];
    logic                   lane_ovf [NACC];
    mac_op_e                op;

    assign op = mac_op_e'(op_sel);

    mac_mult #(.OPW(OPW), .ACCW(ACCW)) i_mult (
        .opa(opa), .opb(opb), .a_signed(a_signed), .b_signed(b_signed),
        .frac_mode(frac_mode), .prod(prod)
    );

    for (genvar g = 0; g < NACC; g++) begin : g_lane
        logic lane_en;
        assign lane_en = op_en && (acc_sel == 1'(g));
        mac_lane #(.ACCW(ACCW)) i_lane (
            .clk(clk), .rst_n(rst_n), .en(lane_en), .op(op), .sat_en(sat_en),
            .prod(prod), .acc(lane_acc[g]), .ovf(lane_ovf[g])
        );
    end

    assign acc_a = lane_acc[0];
    assign acc_b = lane_acc[1];
    assign ovf_a = lane_ovf[0];
    assign ovf_b = lane_ovf[1];
endmodule

// File: tb/test_mac_unit.sv
module test_mac_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_en = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic        acc_sel = 1'b0;
    logic        frac_mode = 1'b0;
    logic        a_signed = 1'b0;
    logic        b_signed = 1'b0;
    logic        sat_en = 1'b0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic [39:0] acc_a, acc_b;
    logic        ovf_a, ovf_b;

    longint ref_acc [2];
    bit     ref_ovf [2];
    int     n_cmp = 0;
    int     n_bad = 0;
    string  tag = "R1";
    bit     summary_done = 1'b0;

    localparam longint POS_LIM = (longint'(1) <<< 39) - 1;
    localparam longint NEG_LIM = -(longint'(1) <<< 39);

    always #10 clk = ~clk;

    mac_unit i_mac_unit (
        .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_sel(op_sel), .acc_sel(acc_sel),
        .frac_mode(frac_mode), .a_signed(a_signed), .b_signed(b_signed), .sat_en(sat_en),
        .opa(opa), .opb(opb), .acc_a(acc_a), .acc_b(acc_b), .ovf_a(ovf_a), .ovf_b(ovf_b)
    );

    task automatic compare();
        logic [39:0] ea, eb;
        ea = ref_acc[0][39:0];
        eb = ref_acc[1][39:0];
        n_cmp++;
        if (acc_a !== ea || acc_b !== eb || ovf_a !== ref_ovf[0] || ovf_b !== ref_ovf[1]) begin
            n_bad++;
            $display("FAIL %s: acc_a=%h acc_b=%h ovf=%b%b expected %h %h %b%b",
                     tag, acc_a, acc_b, ovf_a, ovf_b, ea, eb, ref_ovf[0], ref_ovf[1]);
        end
    endtask

    function automatic longint wrap40(longint v);
        longint w;
        w = v & ((longint'(1) <<< 40) - 1);
        if (w > POS_LIM) w = w - (longint'(1) <<< 40);
        return w;
    endfunction

    task automatic step(input bit en, input bit [1:0] op, input bit sel, input bit fr,
                        input bit as, input bit bs, input bit sat,
                        input bit [15:0] a, input bit [15:0] b);
        longint av, bv, p, s;
        @(negedge clk);
        op_en = en; op_sel = op; acc_sel = sel; frac_mode = fr;
        a_signed = as; b_signed = bs; sat_en = sat; opa = a; opb = b;
        av = as ? longint'($signed(a)) : longint'(a);
        bv = bs ? longint'($signed(b)) : longint'(b);
        p = av * bv;
        if (fr) p = p * 2;
        if (en) begin
            case (op)
                2'b00: ref_acc[sel] = p;
                2'b11: begin ref_acc[sel] = 0; ref_ovf[sel] = 1'b0; end
                default: begin
                    s = (op == 2'b01) ? ref_acc[sel] + p : ref_acc[sel] - p;
                    if (s > POS_LIM || s < NEG_LIM) begin
                        ref_ovf[sel] = 1'b1;
                        if (sat) s = (s > POS_LIM) ? POS_LIM : NEG_LIM;
                        else s = wrap40(s);
                    end
                    ref_acc[sel] = s;
                end
            endcase
        end
        @(posedge clk);
        #5;
        compare();
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        summary();
        $finish;
    end

    initial begin
        ref_acc[0] = 0; ref_acc[1] = 0; ref_ovf[0] = 0; ref_ovf[1] = 0;
        tag = "R1";
        repeat (3) @(posedge clk);
        #5 compare();
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk) #5 compare();

        tag = "R2";
        step(1, 2'b01, 0, 0, 1, 1, 0, 16'd300, 16'hFFF6);
        step(1, 2'b01, 0, 0, 1, 1, 0, 16'h8000, 16'h7FFF);
        step(1, 2'b01, 0, 0, 1, 1, 0, 16'd1234, 16'd567);

        tag = "R3";
        step(1, 2'b00, 1, 0, 0, 0, 0, 16'hFFFF, 16'hFFFF);
        step(1, 2'b00, 1, 0, 1, 0, 0, 16'hFFFF, 16'hFFFF);
        step(1, 2'b00, 1, 0, 0, 1, 0, 16'h8000, 16'hFFFF);
        step(1, 2'b01, 1, 1, 0, 0, 0, 16'hFFFF, 16'hFFFF);

        tag = "R4";
        step(1, 2'b00, 0, 1, 1, 1, 1, 16'h8000, 16'h8000);
        if (acc_a !== 40'h00_8000_0000 || ovf_a !== 1'b0) begin
            n_bad++;
            $display("FAIL R4: acc_a=%h expected 0080000000", acc_a);
        end
        n_cmp++;
        step(1, 2'b01, 0, 1, 1, 1, 0, 16'h4000, 16'hC000);

        tag = "R5";
        step(1, 2'b10, 0, 0, 1, 1, 0, 16'd1000, 16'd1000);
        step(1, 2'b10, 1, 1, 1, 0, 0, 16'h8001, 16'hABCD);

        tag = "R6";
        step(1, 2'b00, 1, 0, 1, 1, 0, 16'd7, 16'hFFFD);

        tag = "R10";
        step(0, 2'b11, 0, 0, 1, 1, 0, 16'd5, 16'd5);
        step(0, 2'b01, 1, 1, 0, 0, 1, 16'hFFFF, 16'hFFFF);
        step(1, 2'b01, 1, 0, 1, 1, 0, 16'd9, 16'd9);

        tag = "R9";
        step(1, 2'b11, 0, 0, 0, 0, 0, 16'd0, 16'd0);
        step(1, 2'b11, 1, 0, 0, 0, 0, 16'd0, 16'd0);

        tag = "R7";
        for (int i = 0; i < 70; i++) step(1, 2'b01, 0, 1, 0, 0, 1, 16'hFFFF, 16'hFFFF);
        for (int i = 0; i < 70; i++) step(1, 2'b10, 1, 1, 0, 0, 1, 16'hFFFF, 16'hFFFF);

        tag = "R9";
        step(1, 2'b10, 0, 0, 1, 1, 1, 16'd3, 16'd3);
        step(1, 2'b00, 0, 0, 1, 1, 0, 16'd2, 16'd2);
        step(1, 2'b11, 0, 0, 0, 0, 0, 16'd0, 16'd0);

        tag = "R8";
        for (int i = 0; i < 70; i++) step(1, 2'b01, 0, 1, 0, 0, 0, 16'hFFFF, 16'hFFFF);
        for (int i = 0; i < 70; i++) step(1, 2'b10, 1, 1, 0, 0, 0, 16'hFFFF, 16'hFFFF);

        tag = "R2";
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], r[3:2], r[4], r[5], r[6], r[7], r[8],
                 16'($urandom), 16'($urandom));
        end

        summary();
        $finish;
    end
endmodule